// File: doc/BRIEF.md
# Display Controller Command Decoder

This block accepts a stream of bytes, each tagged as either a command or a data byte, for a small character-and-icon display controller. It keeps a 6-bit address pointer into a display memory that has gaps in its address space, holds every mode register of the controller, and emits a single write port toward the display memory. A data byte stores a character code or icon dots at the pointer. In icon-blink mode, a data byte instead stores icon blink dots. The pointer then advances. Scan timing and the host interface electricals sit outside this block.

The pointer only ever visits four windows of twelve addresses each: 0–11 and 16–27 hold character codes, and 32–43 and 48–59 hold icon dots. A separate 24-bit array of per-character blink flags is kept here and exposed as a vector. An increment command can write a blank code (0x20) at the old address, clear that character's blink flag, or both, before it steps. A stop command puts the block into standby. While in standby, only a byte with bit 0 set is acted on. That byte wakes the block and is also executed.

Bytes arrive on a valid/ready stream. `in_ready` is high whenever reset is released, so there is no back-pressure. One byte is accepted on every rising clock edge where `in_valid` is high. All outputs are registers, and they reflect an accepted byte from the following edge onward.

Top module: `disp_cmd_decoder`

## Requirements
- R1: After reset, the pointer, all mode registers, the contrast count, the blink array, standby and `mem_we` are 0, and `in_ready` is 1.
- R2: A command `11aaaaaa` loads the pointer with `aaaaaa`. If the low nibble of `aaaaaa` is 12–15, the pointer is loaded with 0 instead.
- R3: A data byte, the increment command `100x101x` and the character-blink command `000x01Cx` each advance the pointer: 11→16, 27→32, 43→48, 59→0, and +1 elsewhere. Every other command leaves the pointer unchanged.
- R4: Outside icon-blink mode, a data byte produces one write with `mem_sel`=0 (display memory), `mem_addr` = the old pointer and `mem_wdata` = the byte.
- R5: The command `100x110B` sets icon-blink mode to B. In that mode, a data byte at pointer 32 or above writes with `mem_sel`=1 (blink memory). At a character address the write is suppressed, but the pointer still advances.
- R6: The option command `1011xxII` stores II. With bit 0 set, each increment command writes 0x20 to display memory at the old pointer.
- R7: The character-blink command sets the blink flag of the character at the pointer to C. The flag index is the address for 0–11 and the address minus 4 for 16–27. With option bit 1 set, each increment command clears that flag at the old pointer.
- R8: The command `100x001U` steps the 3-bit contrast count up (U=1) or down (U=0), wrapping modulo 8.
- R9: The command `100x0100` sets standby, turns the display off and zeroes the pointer. While in standby, bytes with bit 0 clear have no effect. A byte with bit 0 set clears standby and is executed.
- R10: The command `100E100D` sets `disp_on`=D and `icons_only`=E&D.
- R11: `1010xxFF` loads `div_sel`. `100x000B` loads `bank_sel`. `100x011B` loads `so_en`. `100x111B` loads `blink_lit`. `011xxxLL` loads `line_sel`.
- R12: Command codes not listed above (for example `001xxxxx` and `100x0101`) change no output and produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte present on the stream |
| in_ready | output | 1 | Block accepts a byte (high out of reset) |
| in_is_cmd | input | 1 | 1 = command byte, 0 = data byte |
| in_byte | input | 8 | Byte value |
| mem_we | output | 1 | Memory write strobe, one cycle |
| mem_sel | output | 1 | 0 = display memory, 1 = icon blink memory |
| mem_addr | output | 6 | Write address |
| mem_wdata | output | 8 | Write data |
| ptr | output | 6 | Address pointer |
| chr_blink | output | 24 | Per-character blink flags |
| div_sel | output | 2 | Source clock divide select |
| bank_sel | output | 1 | Displayed character bank |
| contrast | output | 3 | Contrast count |
| disp_on | output | 1 | Display enabled |
| icons_only | output | 1 | Show icons only |
| so_en | output | 1 | Serial output enable |
| blink_lit | output | 1 | Blink alternates with all dots lit (1) or dark (0) |
| line_sel | output | 2 | Icon line placement |
| opt_blank | output | 1 | Increment writes blank code |
| opt_unblink | output | 1 | Increment clears character blink |
| icon_blink_mode | output | 1 | Data bytes go to icon blink memory |
| standby | output | 1 | Standby state |

## Verification
The bench builds the block with its default parameters: 12 cells per window, 8-bit bytes and a blank code of 0x20. With these values the whole 64-value pointer load space can be swept, and the full 48-step pointer cycle can be walked twice, once by increments and once by data writes. Expected values come from a modular formula in the bench. The contrast count is driven far enough past both wrap points to check the modulo behaviour. All 32 codes of an unused command group are swept to show that they have no effect. Standby is checked with bytes of both parities of bit 0.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_LOAD, OP_OPT, OP_DIV, OP_BANK, OP_CONTRAST, OP_STOP,
    OP_SERIAL, OP_DISP, OP_INC, OP_ICONBLK, OP_PATTERN, OP_CHB,
    OP_LINE, OP_DATA
  } op_e;

  function automatic op_e decode_byte(input logic is_cmd, input logic [7:0] b);
    op_e op;
    if (!is_cmd) begin
      op = OP_DATA;
    end else begin
      casez (b)
        8'b11??????: op = OP_LOAD;
        8'b1011????: op = OP_OPT;
        8'b1010????: op = OP_DIV;
        8'b100?000?: op = OP_BANK;
        8'b100?001?: op = OP_CONTRAST;
        8'b100?0100: op = OP_STOP;
        8'b100?011?: op = OP_SERIAL;
        8'b100?100?: op = OP_DISP;
        8'b100?101?: op = OP_INC;
        8'b100?110?: op = OP_ICONBLK;
        8'b100?111?: op = OP_PATTERN;
        8'b000?01??: op = OP_CHB;
        8'b011?????: op = OP_LINE;
        default:     op = OP_NONE;
      endcase
    end
    return op;
  endfunction

endpackage

// File: rtl/disp_cmd_decode.sv
module disp_cmd_decode
  import disp_cmd_pkg::*;
(
  input  logic       is_cmd,
  input  logic [7:0] byte_in,
  output op_e        op
);
  always_comb op = decode_byte(is_cmd, byte_in);
endmodule

// File: rtl/disp_ptr_unit.sv
module disp_ptr_unit #(
  parameter int ADDR_W = 6,
  parameter int CELLS  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              do_step,
  input  logic              do_clear,
  output logic [ADDR_W-1:0] ptr
);
  localparam int GRP = 16;
  localparam int SKIP = GRP - CELLS;

  logic [ADDR_W-1:0] folded, stepped;

  always_comb begin
    folded = (load_val[3:0] >= 4'(CELLS)) ? '0 : load_val;
    if (ptr[3:0] == 4'(CELLS - 1))
      stepped = ptr + ADDR_W'(SKIP + 1);
    else
      stepped = ptr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (do_clear) ptr <= '0;
    else if (do_load)  ptr <= folded;
    else if (do_step)  ptr <= stepped;
  end

  a_r2_ptr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    ptr[3:0] < 4'(CELLS));

  a_r3_ptr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_load && !do_step && !do_clear) |=> $stable(ptr));
endmodule

// File: rtl/disp_chr_blink.sv
module disp_chr_blink #(
  parameter int ADDR_W = 6,
  parameter int CELLS  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               do_write,
  input  logic               wr_val,
  output logic [2*CELLS-1:0] flags
);
  localparam int NFLAG = 2 * CELLS;

  logic in_chr;
  logic [$clog2(NFLAG)-1:0] idx;

  always_comb begin
    in_chr = (addr[ADDR_W-1:5] == '0);
    idx = addr[4] ? $clog2(NFLAG)'(CELLS + int'(addr[3:0]))
                  : $clog2(NFLAG)'(addr[3:0]);
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else if (do_write && in_chr && idx == $clog2(NFLAG)'(g)) flags[g] <= wr_val;
    end
  end

  a_r7_one_flag_moves: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags ^ $past(flags)) <= 1);
endmodule

// File: rtl/disp_mode_regs.sv
module disp_mode_regs
  import disp_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  op_e        op,
  input  logic [7:0] b,
  output logic [1:0] div_sel,
  output logic       bank_sel,
  output logic [2:0] contrast,
  output logic       disp_on,
  output logic       icons_only,
  output logic       so_en,
  output logic       blink_lit,
  output logic [1:0] line_sel,
  output logic       opt_blank,
  output logic       opt_unblink,
  output logic       icon_blink_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel <= '0; bank_sel <= 1'b0; contrast <= '0;
      disp_on <= 1'b0; icons_only <= 1'b0; so_en <= 1'b0;
      blink_lit <= 1'b0; line_sel <= '0; opt_blank <= 1'b0;
      opt_unblink <= 1'b0; icon_blink_mode <= 1'b0;
    end else if (exec) begin
      unique case (op)
        OP_OPT:      begin opt_blank <= b[0]; opt_unblink <= b[1]; end
        OP_DIV:      div_sel <= b[1:0];
        OP_BANK:     bank_sel <= b[0];
        OP_CONTRAST: contrast <= b[0] ? contrast + 3'd1 : contrast - 3'd1;
        OP_STOP:     begin disp_on <= 1'b0; icons_only <= 1'b0; end
        OP_SERIAL:   so_en <= b[0];
        OP_DISP:     begin disp_on <= b[0]; icons_only <= b[0] & b[4]; end
        OP_ICONBLK:  icon_blink_mode <= b[0];
        OP_PATTERN:  blink_lit <= b[0];
        OP_LINE:     line_sel <= b[1:0];
        default:     ;
      endcase
    end
  end

  a_r8_contrast_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec && op == OP_CONTRAST) |=> $stable(contrast));

  a_r10_icons_need_on: assert property (@(posedge clk) disable iff (!rst_n)
    icons_only |-> disp_on);
endmodule

// File: rtl/disp_cmd_decoder.sv
module disp_cmd_decoder
  import disp_cmd_pkg::*;
#(
  parameter int        ADDR_W     = 6,
  parameter int        DATA_W     = 8,
  parameter int        CELLS      = 12,
  parameter logic [7:0] BLANK_CODE = 8'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_is_cmd,
  input  logic [DATA_W-1:0]  in_byte,
  output logic               mem_we,
  output logic               mem_sel,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [ADDR_W-1:0]  ptr,
  output logic [2*CELLS-1:0] chr_blink,
  output logic [1:0]         div_sel,
  output logic               bank_sel,
  output logic [2:0]         contrast,
  output logic               disp_on,
  output logic               icons_only,
  output logic               so_en,
  output logic               blink_lit,
  output logic [1:0]         line_sel,
  output logic               opt_blank,
  output logic               opt_unblink,
  output logic               icon_blink_mode,
  output logic               standby
);
  op_e  op;
  logic accept, exec;
  logic blk_we, blk_val;

  assign in_ready = rst_n;
  assign accept   = in_valid && in_ready;
  assign exec     = accept && (!standby || in_byte[0]);

  disp_cmd_decode u_dec (
    .is_cmd (in_is_cmd),
    .byte_in(in_byte[7:0]),
    .op     (op)
  );

  disp_ptr_unit #(.ADDR_W(ADDR_W), .CELLS(CELLS)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .do_load (exec && op == OP_LOAD),
    .load_val(in_byte[ADDR_W-1:0]),
    .do_step (exec && (op == OP_DATA || op == OP_INC || op == OP_CHB)),
    .do_clear(exec && op == OP_STOP),
    .ptr     (ptr)
  );

  always_comb begin
    blk_we  = 1'b0;
    blk_val = 1'b0;
    if (exec && op == OP_CHB) begin
      blk_we = 1'b1; blk_val = in_byte[1];
    end else if (exec && op == OP_INC && opt_unblink) begin
      blk_we = 1'b1; blk_val = 1'b0;
    end
  end

  disp_chr_blink #(.ADDR_W(ADDR_W), .CELLS(CELLS)) u_blink (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (ptr),
    .do_write(blk_we),
    .wr_val  (blk_val),
    .flags   (chr_blink)
  );

  disp_mode_regs u_modes (
    .clk            (clk),
    .rst_n          (rst_n),
    .exec           (exec),
    .op             (op),
    .b              (in_byte[7:0]),
    .div_sel        (div_sel),
    .bank_sel       (bank_sel),
    .contrast       (contrast),
    .disp_on        (disp_on),
    .icons_only     (icons_only),
    .so_en          (so_en),
    .blink_lit      (blink_lit),
    .line_sel       (line_sel),
    .opt_blank      (opt_blank),
    .opt_unblink    (opt_unblink),
    .icon_blink_mode(icon_blink_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    standby <= 1'b0;
    else if (exec && op == OP_STOP) standby <= 1'b1;
    else if (exec)                 standby <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we <= 1'b0; mem_sel <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (exec && op == OP_DATA) begin
        mem_addr  <= ptr;
        mem_wdata <= in_byte;
        mem_sel   <= icon_blink_mode;
        mem_we    <= !icon_blink_mode || ptr[ADDR_W-1];
      end else if (exec && op == OP_INC && opt_blank) begin
        mem_addr  <= ptr;
        mem_wdata <= DATA_W'(BLANK_CODE);
        mem_sel   <= 1'b0;
        mem_we    <= 1'b1;
      end
    end
  end

  a_r4_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[3:0] < 4'(CELLS));

  a_r5_blink_write_icon_space: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_sel) |-> mem_addr[ADDR_W-1]);

  a_r9_sleep_ignores_even: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && in_valid && !in_byte[0]) |=> (standby && !mem_we));

  a_r9_stop_darkens: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_STOP) |=> (standby && !disp_on && ptr == '0));
endmodule

// File: tb/tb_disp_cmd_decoder.sv
module tb_disp_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_cmd = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, mem_we, mem_sel;
  logic [5:0] mem_addr, ptr;
  logic [7:0] mem_wdata;
  logic [23:0] chr_blink;
  logic [1:0] div_sel, line_sel;
  logic [2:0] contrast;
  logic bank_sel, disp_on, icons_only, so_en, blink_lit;
  logic opt_blank, opt_unblink, icon_blink_mode, standby;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  disp_cmd_decoder dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic c, logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_is_cmd = c; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int nxt(int a);
    return ((a & 15) == 11) ? ((a + 5) & 63) : a + 1;
  endfunction

  function automatic int fold(int a);
    return ((a & 15) >= 12) ? 0 : a;
  endfunction

  function automatic int bidx(int a);
    return (a >= 16) ? a - 4 : a;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int exp_p, exp_c;
    logic [63:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ptr", ptr, 0); chk("R1 ready", in_ready, 1);
    chk("R1 modes", {div_sel, bank_sel, contrast, disp_on, icons_only, so_en,
        blink_lit, line_sel, opt_blank, opt_unblink, icon_blink_mode, standby}, 0);
    chk("R1 blink", chr_blink, 0); chk("R1 we", mem_we, 0);

    // R2 load sweep
    for (int v = 0; v < 64; v++) begin
      send(1'b1, 8'hC0 | 8'(v));
      chk("R2 load", ptr, fold(v));
    end

    // R3 increment walk
    send(1'b1, 8'hC0);
    exp_p = 0;
    for (int i = 0; i < 50; i++) begin
      send(1'b1, 8'h8A);
      exp_p = nxt(exp_p);
      chk("R3 step", ptr, exp_p);
      chk("R3 no write", mem_we, 0);
    end

    // R4 data walk
    send(1'b1, 8'hC0);
    exp_p = 0;
    for (int i = 0; i < 48; i++) begin
      send(1'b0, 8'(exp_p) ^ 8'h5A);
      chk("R4 we", mem_we, 1); chk("R4 sel", mem_sel, 0);
      chk("R4 addr", mem_addr, exp_p); chk("R4 data", mem_wdata, exp_p ^ 8'h5A);
      exp_p = nxt(exp_p);
      chk("R3 data step", ptr, exp_p);
    end

    // R5 icon blink mode
    send(1'b1, 8'h8D); chk("R5 mode", icon_blink_mode, 1);
    send(1'b1, 8'hC5); send(1'b0, 8'h11);
    chk("R5 suppressed", mem_we, 0); chk("R5 still steps", ptr, 6);
    send(1'b1, 8'hC0 | 8'd43); send(1'b0, 8'h1F);
    chk("R5 we", mem_we, 1); chk("R5 sel", mem_sel, 1); chk("R5 addr", mem_addr, 43);
    chk("R5 ptr wrap", ptr, 48);
    send(1'b1, 8'h8C); chk("R5 off", icon_blink_mode, 0);

    // R6 blank on increment
    send(1'b1, 8'hB1); send(1'b1, 8'hC3); send(1'b1, 8'h8A);
    chk("R6 we", mem_we, 1); chk("R6 sel", mem_sel, 0);
    chk("R6 addr", mem_addr, 3); chk("R6 data", mem_wdata, 32); chk("R6 ptr", ptr, 4);
    send(1'b1, 8'hB0);

    // R7 character blink set and clear
    for (int a = 0; a < 64; a = nxt(a)) begin
      if (a >= 32) break;
      send(1'b1, 8'hC0 | 8'(a)); send(1'b1, 8'h06);
      chk("R7 set", chr_blink[bidx(a)], 1); chk("R7 step", ptr, nxt(a));
    end
    chk("R7 all set", chr_blink, 24'hFFFFFF);
    send(1'b1, 8'hD1); send(1'b1, 8'h04);
    chk("R7 clear cmd", chr_blink[13], 0);
    send(1'b1, 8'hB2); send(1'b1, 8'hC2); send(1'b1, 8'h8A);
    chk("R7 unblink", chr_blink, 24'hFFDFFB); chk("R7 no write", mem_we, 0);
    send(1'b1, 8'hB0);

    // R8 contrast wrap
    exp_c = 0;
    for (int i = 0; i < 19; i++) begin
      send(1'b1, 8'h83); exp_c = (exp_c + 1) % 8; chk("R8 up", contrast, exp_c);
    end
    for (int i = 0; i < 21; i++) begin
      send(1'b1, 8'h82); exp_c = (exp_c + 7) % 8; chk("R8 down", contrast, exp_c);
    end

    // R10 display modes
    send(1'b1, 8'h89); chk("R10 on", {disp_on, icons_only}, 2);
    send(1'b1, 8'h99); chk("R10 icons", {disp_on, icons_only}, 3);
    send(1'b1, 8'h98); chk("R10 off", {disp_on, icons_only}, 0);

    // R11 other registers
    send(1'b1, 8'hA3); chk("R11 div", div_sel, 3);
    send(1'b1, 8'h81); chk("R11 bank", bank_sel, 1);
    send(1'b1, 8'h87); chk("R11 serial", so_en, 1);
    send(1'b1, 8'h8F); chk("R11 pattern", blink_lit, 1);
    send(1'b1, 8'h62); chk("R11 line", line_sel, 2);

    // R12 unlisted codes
    send(1'b1, 8'hC0 | 8'd37);
    snap = {ptr, chr_blink, div_sel, bank_sel, contrast, disp_on, icons_only,
            so_en, blink_lit, line_sel, opt_blank, opt_unblink, icon_blink_mode, standby};
    for (int b = 32; b < 64; b++) begin
      send(1'b1, 8'(b));
      chk("R12 ignored", ({ptr, chr_blink, div_sel, bank_sel, contrast, disp_on,
          icons_only, so_en, blink_lit, line_sel, opt_blank, opt_unblink,
          icon_blink_mode, standby} == snap) ? 1 : 0, 1);
      chk("R12 no write", mem_we, 0);
    end
    send(1'b1, 8'h85); chk("R12 odd stop", standby, 0);

    // R9 standby
    send(1'b1, 8'h89); send(1'b1, 8'h84);
    chk("R9 standby", standby, 1); chk("R9 dark", disp_on, 0); chk("R9 ptr", ptr, 0);
    send(1'b1, 8'h82); chk("R9 even ignored", contrast, exp_c); chk("R9 still", standby, 1);
    send(1'b0, 8'h40); chk("R9 even data", mem_we, 0); chk("R9 ptr held", ptr, 0);
    send(1'b1, 8'h89); chk("R9 wake", standby, 0); chk("R9 executed", disp_on, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule